// File: doc/BRIEF.md
# Configuration Port Front End for a Legacy I/O Controller

This block is the configuration-space front end of a multi-function peripheral controller on a byte-wide legacy I/O bus. It watches a pair of adjacent I/O addresses: an index port and a data port. The pair sits at 0x4E/0x4F after power-up, or at 0x2E/0x2F when a strap input is high. Configuration space stays locked until software writes a two-byte unlock key to the index port. A separate one-byte key locks it again.

While unlocked, a write to the index port picks a register, and the next data-port read or write goes to that register. There is one global clock-configuration register and a logical-device selector. Behind the selector sits a bank of per-device registers: an activate bit and a 16-bit I/O base. The block exports a per-device enable, a per-device base address and a clock-select bit to the logical devices. Those devices are not part of this block. Software brings a device up in a fixed order: clear activate, program the base, set activate.

Top module: `sio_cfg_port`

## Requirements
- R1: Configuration mode opens only after two consecutive index-port writes of 0x87. An index-port write of any other value while locked resets the key matcher. Data-port writes and writes to other addresses do not affect the matcher.
- R2: An index-port write of 0xAA while in configuration mode returns the block to the locked state. That write does not change the index register.
- R3: With `strap_alt` low the index/data ports are 0x4E/0x4F, and with it high they are 0x2E/0x2F. Accesses to any other address have no effect, and reads of such addresses return 0xFF.
- R4: While locked, data-port writes are ignored, index-port writes do not change the index register, and reads of either port return 0xFF.
- R5: In configuration mode an index-port write (other than 0xAA) loads the index register. An index-port read returns it. A data-port access reads or writes the register the index selects, with read data valid combinationally in the cycle `io_rd` is high.
- R6: Global index 0x24 is an 8-bit read/write register. Its bit 6 drives `clk48_sel`, and all other bits keep their written values.
- R7: Index 0x07 holds an 8-bit logical device number that selects which bank the banked indices reach. For a number of NUM_DEV or more, banked reads return 0x00 and banked writes have no effect.
- R8: Bit 0 of banked index 0x30 is the device's activate bit and drives its `dev_en` bit. The other bits of 0x30 read as 0.
- R9: Banked indices 0x60 and 0x61 hold the high and low bytes of the device's I/O base. The exported `dev_base` slice (bits 16*d+15 down to 16*d) follows the programmed base within two cycles while the device is inactive, and holds its value while the device is active.
- R10: Reads of unimplemented indices return 0x00, and writes to them have no effect.
- R11: After reset the block is locked, the index register and the device number are 0x00, register 0x24 is 0x00, and every device is inactive with a zero base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects the alternate port pair 0x2E/0x2F |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not a decoded configuration read |
| dev_en | output | NUM_DEV | Per-device enable |
| dev_base | output | 16*NUM_DEV | Per-device exported I/O base |
| clk48_sel | output | 1 | Clock input select |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle, that each strobe marks exactly one access, and that `strap_alt` changes only while the block is locked and no access is in flight. The bench drives every access as a single-cycle strobe, issues reads and writes one at a time, and changes the strap only in a directed phase after the exit key. The random phase draws index values mostly from the implemented set and the two keys, so that unlock, relock and banked accesses all occur often.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int BYTE_W = 8;
  localparam int BASE_W = 16;

  localparam logic [BYTE_W-1:0] KEY_UNLOCK = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_RELOCK = 8'hAA;

  localparam logic [BYTE_W-1:0] IX_DEVNUM  = 8'h07;
  localparam logic [BYTE_W-1:0] IX_CLKCFG  = 8'h24;
  localparam logic [BYTE_W-1:0] IX_ACTIVE  = 8'h30;
  localparam logic [BYTE_W-1:0] IX_BASE_HI = 8'h60;
  localparam logic [BYTE_W-1:0] IX_BASE_LO = 8'h61;

  localparam int CLK48_BIT = 6;

  localparam logic [BYTE_W-1:0] IDLE_READ = 8'hFF;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

endpackage

// File: rtl/sio_key_unlock.sv
module sio_key_unlock
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              cfg_open,
  output logic              idx_load
);

  lock_state_e state_q, state_d;
  logic        state_en;

  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    idx_load = 1'b0;
    if (idx_wr) begin
      state_en = 1'b1;
      unique case (state_q)
        LK_LOCKED: state_d = (wdata == KEY_UNLOCK) ? LK_HALF : LK_LOCKED;
        LK_HALF:   state_d = (wdata == KEY_UNLOCK) ? LK_OPEN : LK_LOCKED;
        LK_OPEN: begin
          if (wdata == KEY_RELOCK) begin
            state_d = LK_LOCKED;
          end else begin
            state_d  = LK_OPEN;
            idx_load = 1'b1;
          end
        end
        default: state_d = LK_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_LOCKED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign cfg_open = (state_q == LK_OPEN);

endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_load,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] idx_q,
  output logic [BYTE_W-1:0] devnum_q,
  output logic [BYTE_W-1:0] clkcfg_q
);

  logic [BYTE_W-1:0] idx_d, devnum_d, clkcfg_d;
  logic              idx_en, devnum_en, clkcfg_en;

  always_comb begin
    idx_en    = idx_load;
    idx_d     = wdata;
    devnum_en = data_wr && (idx_q == IX_DEVNUM);
    devnum_d  = wdata;
    clkcfg_en = data_wr && (idx_q == IX_CLKCFG);
    clkcfg_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devnum_q <= '0;
    end else if (devnum_en) begin
      devnum_q <= devnum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkcfg_q <= '0;
    end else if (clkcfg_en) begin
      clkcfg_q <= clkcfg_d;
    end
  end

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [BYTE_W-1:0] idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] bank_rdata,
  output logic              active,
  output logic [BASE_W-1:0] base_out
);

  logic              act_q, act_d, act_en;
  logic [BYTE_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              hi_en, lo_en;
  logic [BASE_W-1:0] out_q, out_d;
  logic              out_en;

  always_comb begin
    act_en = bank_wr && (idx == IX_ACTIVE);
    act_d  = wdata[0];
    hi_en  = bank_wr && (idx == IX_BASE_HI);
    hi_d   = wdata;
    lo_en  = bank_wr && (idx == IX_BASE_LO);
    lo_d   = wdata;
    out_en = !act_q;
    out_d  = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_comb begin
    unique case (idx)
      IX_ACTIVE:  bank_rdata = {{(BYTE_W-1){1'b0}}, act_q};
      IX_BASE_HI: bank_rdata = hi_q;
      IX_BASE_LO: bank_rdata = lo_q;
      default:    bank_rdata = '0;
    endcase
  end

  assign active   = act_q;
  assign base_out = out_q;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter int              NUM_DEV      = 4,
  parameter logic [ADDR_W-1:0] PRI_IDX_ADDR = 16'h004E,
  parameter logic [ADDR_W-1:0] ALT_IDX_ADDR = 16'h002E
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strap_alt,
  input  logic [ADDR_W-1:0]         io_addr,
  input  logic                      io_wr,
  input  logic                      io_rd,
  input  logic [BYTE_W-1:0]         io_wdata,
  output logic [BYTE_W-1:0]         io_rdata,
  output logic [NUM_DEV-1:0]        dev_en,
  output logic [NUM_DEV*BASE_W-1:0] dev_base,
  output logic                      clk48_sel
);

  localparam logic [ADDR_W-1:0] ONE_ADDR = ADDR_W'(1);

  logic [ADDR_W-1:0] idx_addr, dat_addr;
  logic              idx_hit, dat_hit;
  logic              cfg_open, idx_load, data_wr;
  logic [BYTE_W-1:0] idx_q, devnum_q, clkcfg_q;
  logic [BYTE_W-1:0] bank_rd [NUM_DEV];
  logic [BYTE_W-1:0] bank_sel_rd;
  logic              dev_valid;
  logic [BYTE_W-1:0] reg_rd;

  always_comb begin
    idx_addr = strap_alt ? ALT_IDX_ADDR : PRI_IDX_ADDR;
    dat_addr = idx_addr + ONE_ADDR;
    idx_hit  = (io_addr == idx_addr);
    dat_hit  = (io_addr == dat_addr);
    data_wr  = io_wr && dat_hit && cfg_open;
  end

  sio_key_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (io_wr && idx_hit),
    .wdata    (io_wdata),
    .cfg_open (cfg_open),
    .idx_load (idx_load)
  );

  sio_global_regs u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_load (idx_load),
    .data_wr  (data_wr),
    .wdata    (io_wdata),
    .idx_q    (idx_q),
    .devnum_q (devnum_q),
    .clkcfg_q (clkcfg_q)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    logic sel;
    assign sel = (devnum_q == BYTE_W'(d));
    sio_ldev_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_wr    (data_wr && sel),
      .idx        (idx_q),
      .wdata      (io_wdata),
      .bank_rdata (bank_rd[d]),
      .active     (dev_en[d]),
      .base_out   (dev_base[d*BASE_W +: BASE_W])
    );
  end

  always_comb begin
    bank_sel_rd = '0;
    dev_valid   = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (devnum_q == BYTE_W'(d)) begin
        bank_sel_rd = bank_rd[d];
        dev_valid   = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (idx_q)
      IX_DEVNUM:  reg_rd = devnum_q;
      IX_CLKCFG:  reg_rd = clkcfg_q;
      IX_ACTIVE,
      IX_BASE_HI,
      IX_BASE_LO: reg_rd = dev_valid ? bank_sel_rd : '0;
      default:    reg_rd = '0;
    endcase
  end

  always_comb begin
    io_rdata = IDLE_READ;
    if (io_rd && cfg_open) begin
      if (idx_hit) begin
        io_rdata = idx_q;
      end else if (dat_hit) begin
        io_rdata = reg_rd;
      end
    end
  end

  assign clk48_sel = clkcfg_q[CLK48_BIT];

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter int              NUM_DEV      = 4,
  parameter logic [ADDR_W-1:0] PRI_IDX_ADDR = 16'h004E,
  parameter logic [ADDR_W-1:0] ALT_IDX_ADDR = 16'h002E
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      strap_alt,
  input logic [ADDR_W-1:0]         io_addr,
  input logic                      io_wr,
  input logic                      io_rd,
  input logic [BYTE_W-1:0]         io_wdata,
  input logic [BYTE_W-1:0]         io_rdata,
  input logic [NUM_DEV-1:0]        dev_en,
  input logic [NUM_DEV*BASE_W-1:0] dev_base,
  input logic                      cfg_open,
  input logic [BYTE_W-1:0]         idx_q
);

  logic [ADDR_W-1:0] ck_idx, ck_dat;
  logic              ck_idx_hit, ck_foreign;

  assign ck_idx     = strap_alt ? ALT_IDX_ADDR : PRI_IDX_ADDR;
  assign ck_dat     = ck_idx + ADDR_W'(1);
  assign ck_idx_hit = (io_addr == ck_idx);
  assign ck_foreign = (io_addr != ck_idx) && (io_addr != ck_dat);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && ck_idx_hit && io_wdata == KEY_UNLOCK))
    else $error("open without unlock key"); // R1

  AST_RELOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && ck_idx_hit && io_wdata == KEY_RELOCK) |=> !cfg_open)
    else $error("relock key ignored"); // R2

  AST_FOREIGN_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && ck_foreign) |-> io_rdata == IDLE_READ)
    else $error("foreign read returned data"); // R3

  AST_LOCKED_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_open) |-> io_rdata == IDLE_READ)
    else $error("locked read returned data"); // R4

  AST_INDEX_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(idx_q))
    else $error("index changed while locked"); // R4

  AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && cfg_open && ck_idx_hit) |-> io_rdata == idx_q)
    else $error("index port read mismatch"); // R5

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    AST_BASE_HELD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dev_en[d]) |-> $stable(dev_base[d*BASE_W +: BASE_W]))
      else $error("exported base moved while active"); // R9
  end

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W       (ADDR_W),
  .NUM_DEV      (NUM_DEV),
  .PRI_IDX_ADDR (PRI_IDX_ADDR),
  .ALT_IDX_ADDR (ALT_IDX_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strap_alt (strap_alt),
  .io_addr   (io_addr),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .dev_en    (dev_en),
  .dev_base  (dev_base),
  .cfg_open  (cfg_open),
  .idx_q     (idx_q)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;

  localparam int NDEV = 4;

  logic              clk;
  logic              rst_n;
  logic              strap_alt;
  logic [15:0]       io_addr;
  logic              io_wr;
  logic              io_rd;
  logic [7:0]        io_wdata;
  logic [7:0]        io_rdata;
  logic [NDEV-1:0]   dev_en;
  logic [NDEV*16-1:0] dev_base;
  logic              clk48_sel;

  sio_cfg_port #(.ADDR_W(16), .NUM_DEV(NDEV)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_alt (strap_alt),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .dev_en    (dev_en),
    .dev_base  (dev_base),
    .clk48_sel (clk48_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Bench model of the configuration space
  int       m_state;  // 0 locked, 1 one key seen, 2 open
  bit [7:0] m_idx, m_dev, m_clk;
  bit       m_act [NDEV];
  bit [7:0] m_hi [NDEV];
  bit [7:0] m_lo [NDEV];
  bit [15:0] m_exp [NDEV];

  function automatic bit [15:0] idx_port();
    return strap_alt ? 16'h002E : 16'h004E;
  endfunction

  function automatic bit [7:0] model_reg(bit [7:0] ix);
    bit ok;
    ok = (m_dev < NDEV);
    case (ix)
      8'h07: return m_dev;
      8'h24: return m_clk;
      8'h30: return ok ? {7'b0, m_act[m_dev]} : 8'h00;
      8'h60: return ok ? m_hi[m_dev] : 8'h00;
      8'h61: return ok ? m_lo[m_dev] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit [7:0] model_read(bit [15:0] a);
    if (m_state != 2) return 8'hFF;
    if (a == idx_port()) return m_idx;
    if (a == idx_port() + 16'd1) return model_reg(m_idx);
    return 8'hFF;
  endfunction

  task automatic model_write(bit [15:0] a, bit [7:0] d);
    if (a == idx_port()) begin
      if (m_state == 2) begin
        if (d == 8'hAA) m_state = 0;
        else m_idx = d;
      end else if (d == 8'h87) begin
        m_state = m_state + 1;
      end else begin
        m_state = 0;
      end
    end else if (a == idx_port() + 16'd1 && m_state == 2) begin
      case (m_idx)
        8'h07: m_dev = d;
        8'h24: m_clk = d;
        8'h30: if (m_dev < NDEV) m_act[m_dev] = d[0];
        8'h60: if (m_dev < NDEV) m_hi[m_dev] = d;
        8'h61: if (m_dev < NDEV) m_lo[m_dev] = d;
        default: ;
      endcase
    end
    for (int k = 0; k < NDEV; k++)
      if (!m_act[k]) m_exp[k] = {m_hi[k], m_lo[k]};
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(bit [15:0] a, bit [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_rd(bit [15:0] a, output bit [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2;
    d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic rd_check(string req, bit [15:0] a, bit [7:0] exp);
    bit [7:0] d;
    bus_rd(a, d);
    check(req, "read", d, exp);
    check(req, "model", d, model_read(a));
  endtask

  task automatic check_exports(string req);
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NDEV; k++) begin
      check(req, "dev_base", dev_base[k*16 +: 16], m_exp[k]);
      check(req, "dev_en", dev_en[k], m_act[k]);
    end
    check("R6", "clk48_sel", clk48_sel, m_clk[6]);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [7:0] ixset [8];
    rst_n = 1'b0; strap_alt = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    m_state = 0; m_idx = 0; m_dev = 0; m_clk = 0;
    for (int k = 0; k < NDEV; k++) begin
      m_act[k] = 0; m_hi[k] = 0; m_lo[k] = 0; m_exp[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11", "dev_en", dev_en, 0);
    check("R11", "dev_base", dev_base, 0);
    check("R11", "clk48_sel", clk48_sel, 0);
    rd_check("R11", 16'h004E, 8'hFF);

    // R4 locked accesses ignored
    bus_wr(16'h004E, 8'h24);
    bus_wr(16'h004F, 8'h5A);
    // R1 broken key then completed key
    bus_wr(16'h004E, 8'h87);
    bus_wr(16'h004E, 8'h12);
    bus_wr(16'h004E, 8'h87);
    rd_check("R1", 16'h004F, 8'hFF);
    bus_wr(16'h004F, 8'h00);  // data write between keys does not reset matcher
    bus_wr(16'h004E, 8'h87);
    rd_check("R1", 16'h004E, 8'h00);
    rd_check("R11", 16'h004F, 8'h00);
    bus_wr(16'h004E, 8'h24);
    rd_check("R4", 16'h004F, 8'h00);

    // R6 clock config read-modify-write
    bus_wr(16'h004F, 8'h15);
    rd_check("R6", 16'h004F, 8'h15);
    check("R6", "clk48_sel", clk48_sel, 0);
    bus_wr(16'h004F, 8'h15 | 8'h40);
    rd_check("R6", 16'h004F, 8'h55);
    check("R6", "clk48_sel", clk48_sel, 1);

    // R7 R8 R9 device bring-up on device 2
    bus_wr(16'h004E, 8'h07); bus_wr(16'h004F, 8'h02);
    rd_check("R7", 16'h004F, 8'h02);
    bus_wr(16'h004E, 8'h30); bus_wr(16'h004F, 8'h00);
    bus_wr(16'h004E, 8'h60); bus_wr(16'h004F, 8'h03);
    bus_wr(16'h004E, 8'h61); bus_wr(16'h004F, 8'hF8);
    bus_wr(16'h004E, 8'h30); bus_wr(16'h004F, 8'h01);
    check_exports("R9");
    check("R9", "dev2 base", dev_base[32 +: 16], 16'h03F8);
    check("R8", "dev2 en", dev_en, 4'b0100);
    bus_wr(16'h004E, 8'h60); bus_wr(16'h004F, 8'h02);
    check_exports("R9");
    check("R9", "dev2 base held", dev_base[32 +: 16], 16'h03F8);
    rd_check("R9", 16'h004F, 8'h02);
    bus_wr(16'h004E, 8'h30); bus_wr(16'h004F, 8'hFF);
    rd_check("R8", 16'h004F, 8'h01);
    bus_wr(16'h004F, 8'h00);
    check_exports("R9");
    check("R9", "dev2 base follows", dev_base[32 +: 16], 16'h02F8);
    check("R8", "dev2 en off", dev_en, 4'b0000);

    // R7 out-of-range device number
    bus_wr(16'h004E, 8'h07); bus_wr(16'h004F, 8'h09);
    bus_wr(16'h004E, 8'h30); bus_wr(16'h004F, 8'h01);
    rd_check("R7", 16'h004F, 8'h00);
    check_exports("R7");
    check("R7", "dev_en", dev_en, 4'b0000);

    // R10 unimplemented index
    bus_wr(16'h004E, 8'h55); bus_wr(16'h004F, 8'h33);
    rd_check("R10", 16'h004F, 8'h00);
    rd_check("R5", 16'h004E, 8'h55);

    // R3 foreign address while open
    rd_check("R3", 16'h0050, 8'hFF);
    bus_wr(16'h0050, 8'hAA);
    rd_check("R3", 16'h004E, 8'h55);

    // R2 relock
    bus_wr(16'h004E, 8'hAA);
    rd_check("R2", 16'h004F, 8'hFF);
    rd_check("R2", 16'h004E, 8'hFF);

    // R3 alternate pair
    @(negedge clk); strap_alt = 1'b1;
    bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h87);
    rd_check("R3", 16'h002E, 8'hFF);
    bus_wr(16'h002E, 8'h87); bus_wr(16'h002E, 8'h87);
    rd_check("R3", 16'h002E, 8'h55);
    rd_check("R3", 16'h004E, 8'hFF);
    bus_wr(16'h002E, 8'hAA);
    rd_check("R2", 16'h002F, 8'hFF);
    @(negedge clk); strap_alt = 1'b0;

    // Random phase, checked against the model
    void'($urandom(32'h5EED_0C0F));
    ixset = '{8'h87, 8'hAA, 8'h07, 8'h24, 8'h30, 8'h60, 8'h61, 8'h55};
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit [7:0] v;
      r = $urandom_range(99);
      if (r < 40) begin
        v = ($urandom_range(9) < 8) ? ixset[$urandom_range(7)] : 8'($urandom);
        bus_wr(16'h004E, v);
      end else if (r < 68) begin
        v = (m_idx == 8'h07) ? 8'($urandom_range(5)) : 8'($urandom);
        bus_wr(16'h004F, v);
      end else if (r < 95) begin
        bit [7:0] d;
        bit [15:0] a;
        a = ($urandom_range(1) == 0) ? 16'h004E : 16'h004F;
        bus_rd(a, d);
        check("R5", "random read", d, model_read(a));
      end else begin
        bus_wr(16'h0040 + 16'($urandom_range(7)), 8'($urandom));
      end
      if (n % 50 == 49) check_exports("R9");
    end
    check_exports("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule